// File: doc/BRIEF.md
# Operand Address Sequencer

This block works out the 16-bit operand address of one instruction of an 8-bit processor. When it accepts a request it takes a 4-bit addressing-mode code, the two index registers and the address of the first operand byte. It then reads operand bytes, and pointer bytes where the mode needs them, over a single-port byte memory with one-cycle read latency. It issues at most one read per cycle. When it finishes, it presents the operand address, the program counter value that follows the consumed bytes, and a flag that tells the caller a page boundary was crossed.

The caller uses the page-crossing flag to account for extra cycles. Operand use, arithmetic and flags stay with the caller. The block keeps page-wrapping behaviour in three places: zero-page index sums, zero-page pointer fetches and the high-byte fetch of an absolute indirect pointer. Software written for such a processor depends on all three.

Top module: `ea_addr_gen`

## Requirements
- R1: After reset `ea_valid`, `busy` and `mem_rd` are all 0.
- R2: Mode code 2 (immediate) finishes in one cycle with no memory read. It returns `pc_in` as the address and `pc_in + 1` (mod 65536) as the next PC.
- R3: Mode codes 0 (implied), 1 (accumulator) and the unused codes 13 to 15 finish in one cycle with no memory read. They return address 0 and leave the next PC equal to `pc_in`.
- R4: Mode code 3 (zero page) returns the operand byte. Codes 4 and 5 return (operand + X) mod 256 and (operand + Y) mod 256. The high byte of the result is always 0, and the next PC is `pc_in + 1`.
- R5: Mode code 6 (absolute) reads the low byte at `pc_in` and the high byte at `pc_in + 1`, and sets the next PC to `pc_in + 2`. Codes 7 and 8 add X or Y to that 16-bit base with full carry. For codes 7 and 8, `page_cross` is 1 exactly when the high byte of the result differs from the high byte of the base.
- R6: Mode code 9 (relative) sign-extends the operand byte and adds it to `pc_in + 1`, which is also the next PC. `page_cross` is 1 when the target page differs from the page of `pc_in + 1`.
- R7: Mode code 10 (pre-indexed indirect) forms the pointer p = (operand + X) mod 256. It reads the low byte at p and the high byte at (p + 1) mod 256, both in page zero.
- R8: Mode code 11 (post-indexed indirect) reads a pointer at the operand byte o and at (o + 1) mod 256 in page zero, then adds Y with full 16-bit carry. `page_cross` compares the high byte of the pointer with the high byte of the result.
- R9: Mode code 12 (absolute indirect) reads a 16-bit pointer. It reads the target low byte at that pointer and the high byte at the same page with the pointer low byte incremented mod 256. The next PC is `pc_in + 2`.
- R10: A mode that reads r bytes (r of 1 to 4) raises `ea_valid` r + 2 cycles after the accepting clock edge and issues exactly r reads. Modes 0, 1, 2 and 13 to 15 raise it after 1 cycle, and `ea_valid` lasts one cycle per result.
- R11: While `busy` is 1, `start` is ignored. The running request completes with its own result and produces no extra `ea_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when `busy` is 0 |
| mode | input | 4 | Addressing-mode code |
| pc_in | input | 16 | Address of the first operand byte |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| ea | output | 16 | Operand address |
| pc_next | output | 16 | Program counter after the consumed bytes |
| page_cross | output | 1 | Indexed or branch result left the base page |
| ea_valid | output | 1 | One-cycle strobe marking a new result |
| busy | output | 1 | A multi-cycle request is in progress |

## Verification
The bench targets each wrap point. Zero-page sums that overflow past 0xFF would land in page one if the carry were kept. Pre- and post-indexed pointers at 0xFF would fetch their high byte from 0x0100. An absolute indirect pointer at 0x30FF would take its high byte from 0x3100 instead of 0x3000. Backward branches that leave the page, and indexed sums that carry, show up as a wrong high byte or a missing `page_cross`. A restart while busy would show up as a corrupted result or a stray second strobe. The read count and latency checks catch a sequencer that skips or repeats a fetch.

// File: rtl/ea_addr_pkg.sv
package ea_addr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2 * BYTE_W;
  localparam int unsigned MODE_W = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL   = 4'd0,
    AM_ACCU   = 4'd1,
    AM_IMMD   = 4'd2,
    AM_ZPG    = 4'd3,
    AM_ZPGX   = 4'd4,
    AM_ZPGY   = 4'd5,
    AM_ABSO   = 4'd6,
    AM_ABSX   = 4'd7,
    AM_ABSY   = 4'd8,
    AM_RELV   = 4'd9,
    AM_PREIX  = 4'd10,
    AM_POSTIY = 4'd11,
    AM_INDJ   = 4'd12
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP0, ST_OP1, ST_PLO, ST_PHI, ST_LAST
  } step_e;

  // number of operand bytes read at PC
  function automatic logic [1:0] operand_len(logic [MODE_W-1:0] m);
    case (m)
      AM_ZPG, AM_ZPGX, AM_ZPGY, AM_RELV, AM_PREIX, AM_POSTIY: return 2'd1;
      AM_ABSO, AM_ABSX, AM_ABSY, AM_INDJ:                     return 2'd2;
      default:                                                return 2'd0;
    endcase
  endfunction

  function automatic logic via_pointer(logic [MODE_W-1:0] m);
    return (m == AM_PREIX) || (m == AM_POSTIY) || (m == AM_INDJ);
  endfunction

  // sum kept inside page zero
  function automatic addr_t zp_sum(byte_t a, byte_t i);
    byte_t s;
    s = a + i;
    return {byte_t'(0), s};
  endfunction

  // next byte inside the same page
  function automatic addr_t same_page_next(addr_t p);
    byte_t l;
    l = p[BYTE_W-1:0] + byte_t'(1);
    return {p[ADDR_W-1:BYTE_W], l};
  endfunction

  function automatic addr_t wide_add(addr_t b, byte_t i);
    return b + {byte_t'(0), i};
  endfunction

  function automatic addr_t branch_dest(addr_t p, byte_t off);
    return p + {{BYTE_W{off[BYTE_W-1]}}, off};
  endfunction

  function automatic logic page_moved(addr_t a, addr_t b);
    return a[ADDR_W-1:BYTE_W] != b[ADDR_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/ea_step_ctl.sv
module ea_step_ctl
  import ea_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  output step_e             st,
  output step_e             prev_st,
  output logic [MODE_W-1:0] mode_q,
  output logic              accept,
  output logic              quick_fin,
  output logic              rd_issue
);
  logic [1:0] len_in;
  logic [1:0] len_q;
  step_e      st_n;

  assign len_in    = operand_len(mode_in);
  assign accept    = (st == ST_IDLE) && start;
  assign quick_fin = accept && (len_in == 2'd0);
  assign rd_issue  = (st == ST_OP0) || (st == ST_OP1) ||
                     (st == ST_PLO) || (st == ST_PHI);

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (accept && (len_in != 2'd0)) st_n = ST_OP0;
      ST_OP0:  st_n = (len_q == 2'd2) ? ST_OP1 :
                      (via_pointer(mode_q) ? ST_PLO : ST_LAST);
      ST_OP1:  st_n = via_pointer(mode_q) ? ST_PLO : ST_LAST;
      ST_PLO:  st_n = ST_PHI;
      ST_PHI:  st_n = ST_LAST;
      ST_LAST: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      prev_st <= ST_IDLE;
      mode_q  <= '0;
      len_q   <= 2'd0;
    end else begin
      st      <= st_n;
      prev_st <= st;
      if (accept) begin
        mode_q <= mode_in;
        len_q  <= len_in;
      end
    end
  end

  // R11: a running request keeps its mode whatever start does
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(mode_q));

  // R10: the final capture step always follows a memory read step
  a_r10_last_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAST) |-> ((prev_st == ST_OP0) || (prev_st == ST_OP1) || (prev_st == ST_PHI)));
endmodule

// File: rtl/ea_addr_path.sv
module ea_addr_path
  import ea_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             st,
  input  step_e             prev_st,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              accept,
  input  logic              quick_fin,
  input  addr_t             pc_in,
  input  byte_t             x_in,
  input  byte_t             y_in,
  input  byte_t             mem_rdata,
  output addr_t             mem_addr,
  output addr_t             ea_q,
  output addr_t             pc_out,
  output logic              cross_q,
  output logic              done_q
);
  addr_t pc_q, ptr_q;
  byte_t x_q, y_q, lo_q, hi_q, plo_q;

  // freshest view of each captured byte
  byte_t lo_v, hi_v, plo_v;
  addr_t ptr_sel, base_abs, ind_word, fin_ea, quick_ea, quick_pc;
  logic  fin_cross, last_take, op_step;

  assign lo_v  = (prev_st == ST_OP0) ? mem_rdata : lo_q;
  assign hi_v  = (prev_st == ST_OP1) ? mem_rdata : hi_q;
  assign plo_v = (prev_st == ST_PLO) ? mem_rdata : plo_q;

  assign base_abs  = {hi_v, lo_v};
  assign ind_word  = {mem_rdata, plo_v};
  assign last_take = (st == ST_LAST);
  assign op_step   = (st == ST_OP0) || (st == ST_OP1);

  always_comb begin
    case (mode_q)
      AM_PREIX:  ptr_sel = zp_sum(lo_v, x_q);
      AM_POSTIY: ptr_sel = {byte_t'(0), lo_v};
      default:   ptr_sel = base_abs;
    endcase
  end

  always_comb begin
    case (st)
      ST_PLO:  mem_addr = ptr_sel;
      ST_PHI:  mem_addr = same_page_next(ptr_q);
      default: mem_addr = pc_q;
    endcase
  end

  always_comb begin
    fin_cross = 1'b0;
    case (mode_q)
      AM_ZPG:    fin_ea = {byte_t'(0), lo_v};
      AM_ZPGX:   fin_ea = zp_sum(lo_v, x_q);
      AM_ZPGY:   fin_ea = zp_sum(lo_v, y_q);
      AM_ABSO:   fin_ea = base_abs;
      AM_ABSX: begin
        fin_ea    = wide_add(base_abs, x_q);
        fin_cross = page_moved(base_abs, fin_ea);
      end
      AM_ABSY: begin
        fin_ea    = wide_add(base_abs, y_q);
        fin_cross = page_moved(base_abs, fin_ea);
      end
      AM_RELV: begin
        fin_ea    = branch_dest(pc_q, lo_v);
        fin_cross = page_moved(pc_q, fin_ea);
      end
      AM_PREIX:  fin_ea = ind_word;
      AM_POSTIY: begin
        fin_ea    = wide_add(ind_word, y_q);
        fin_cross = page_moved(ind_word, fin_ea);
      end
      AM_INDJ:   fin_ea = ind_word;
      default:   fin_ea = pc_q;
    endcase
  end

  assign quick_ea = (mode_in == AM_IMMD) ? pc_in : addr_t'(0);
  assign quick_pc = (mode_in == AM_IMMD) ? pc_in + addr_t'(1) : pc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ptr_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      plo_q   <= '0;
      ea_q    <= '0;
      pc_out  <= '0;
      cross_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      lo_q  <= lo_v;
      hi_q  <= hi_v;
      plo_q <= plo_v;
      if (accept) begin
        pc_q <= pc_in;
        x_q  <= x_in;
        y_q  <= y_in;
      end else if (op_step) begin
        pc_q <= pc_q + addr_t'(1);
      end
      if (st == ST_PLO) ptr_q <= ptr_sel;
      done_q <= quick_fin || last_take;
      if (quick_fin) begin
        ea_q    <= quick_ea;
        pc_out  <= quick_pc;
        cross_q <= 1'b0;
      end else if (last_take) begin
        ea_q    <= fin_ea;
        pc_out  <= pc_q;
        cross_q <= fin_cross;
      end
    end
  end

  // R4: zero-page results never leave page zero
  a_r4_zp_page0: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ((mode_q == AM_ZPG) || (mode_q == AM_ZPGX) || (mode_q == AM_ZPGY)))
      |-> (ea_q[ADDR_W-1:BYTE_W] == '0));

  // R7, R8: second pointer fetch of the indexed indirect modes stays in page zero
  a_r7_ptr_hi_page0: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PHI) && (mode_q != AM_INDJ)) |-> (mem_addr[ADDR_W-1:BYTE_W] == '0));

  // R9: absolute indirect high-byte fetch stays on the pointer's page
  a_r9_ind_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PHI) && (mode_q == AM_INDJ))
      |-> (mem_addr[ADDR_W-1:BYTE_W] == $past(mem_addr[ADDR_W-1:BYTE_W])));

  // R2: immediate result is one byte ahead of its address
  a_r2_imm_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (mode_q == AM_IMMD)) |-> (pc_out == addr_t'(ea_q + addr_t'(1))));

  // R3: implied and accumulator forms give address zero
  a_r3_impl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ((mode_q == AM_IMPL) || (mode_q == AM_ACCU))) |-> (ea_q == '0));
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_addr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MODE_W-1:0]   mode,
  input  logic [ADDR_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0]   x_idx,
  input  logic [BYTE_W-1:0]   y_idx,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   ea,
  output logic [ADDR_W-1:0]   pc_next,
  output logic                page_cross,
  output logic                ea_valid,
  output logic                busy
);
  step_e             st, prev_st;
  logic [MODE_W-1:0] mode_q;
  logic              accept, quick_fin, rd_issue;

  ea_step_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (mode),
    .st        (st),
    .prev_st   (prev_st),
    .mode_q    (mode_q),
    .accept    (accept),
    .quick_fin (quick_fin),
    .rd_issue  (rd_issue)
  );

  ea_addr_path u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .prev_st   (prev_st),
    .mode_q    (mode_q),
    .mode_in   (mode),
    .accept    (accept),
    .quick_fin (quick_fin),
    .pc_in     (pc_in),
    .x_in      (x_idx),
    .y_in      (y_idx),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .ea_q      (ea),
    .pc_out    (pc_next),
    .cross_q   (page_cross),
    .done_q    (ea_valid)
  );

  assign mem_rd = rd_issue;
  assign busy   = (st != ST_IDLE);

  // R10: reads happen only inside a multi-cycle request
  a_r10_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
endmodule

// File: tb/ea_addr_gen_bench.sv
`timescale 1ns/1ps
module ea_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] pc_in = 16'd0;
  logic [7:0]  x_idx = 8'd0;
  logic [7:0]  y_idx = 8'd0;
  logic [7:0]  mem_rdata = 8'd0;
  logic [15:0] mem_addr, ea, pc_next;
  logic        mem_rd, page_cross, ea_valid, busy;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int ovr_a[8];
  int ovr_d[8];
  int ovr_n = 0;

  always #2.5 clk = ~clk;

  ea_addr_gen u_ea_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_idx(x_idx), .y_idx(y_idx), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .ea(ea), .pc_next(pc_next), .page_cross(page_cross),
    .ea_valid(ea_valid), .busy(busy)
  );

  function automatic int memf(int a);
    for (int i = 0; i < ovr_n; i++) if (ovr_a[i] == a) return ovr_d[i];
    return (((a % 256) * 7) ^ ((a / 256) * 13) ^ 60) & 255;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= 8'(memf(int'(mem_addr)));
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic set_ovr(input int a, input int d);
    ovr_a[ovr_n] = a;
    ovr_d[ovr_n] = d;
    ovr_n++;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int m);
    case (m)
      2: return "R2";
      0, 1, 13, 14, 15: return "R3";
      3, 4, 5: return "R4";
      6, 7, 8: return "R5";
      9: return "R6";
      10: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  // reference behaviour built from the requirements
  function automatic void model(input int m, input int pc, input int x, input int y,
                                output int e, output int np, output int cr,
                                output int rd, output int lat);
    int b0, b1, pt, lo, hi, base, off;
    b0 = memf(pc);
    b1 = memf((pc + 1) % 65536);
    e = 0; np = pc; cr = 0; rd = 0;
    case (m)
      2: begin e = pc; np = (pc + 1) % 65536; end
      3: begin e = b0; np = (pc + 1) % 65536; rd = 1; end
      4: begin e = (b0 + x) % 256; np = (pc + 1) % 65536; rd = 1; end
      5: begin e = (b0 + y) % 256; np = (pc + 1) % 65536; rd = 1; end
      6: begin e = b1 * 256 + b0; np = (pc + 2) % 65536; rd = 2; end
      7, 8: begin
        base = b1 * 256 + b0;
        e = (base + ((m == 7) ? x : y)) % 65536;
        cr = ((base / 256) != (e / 256)) ? 1 : 0;
        np = (pc + 2) % 65536; rd = 2;
      end
      9: begin
        off = (b0 > 127) ? b0 - 256 : b0;
        np = (pc + 1) % 65536;
        e = (np + off + 65536) % 65536;
        cr = ((np / 256) != (e / 256)) ? 1 : 0;
        rd = 1;
      end
      10: begin
        pt = (b0 + x) % 256;
        lo = memf(pt); hi = memf((pt + 1) % 256);
        e = hi * 256 + lo; np = (pc + 1) % 65536; rd = 3;
      end
      11: begin
        lo = memf(b0); hi = memf((b0 + 1) % 256);
        base = hi * 256 + lo;
        e = (base + y) % 65536;
        cr = ((base / 256) != (e / 256)) ? 1 : 0;
        np = (pc + 1) % 65536; rd = 3;
      end
      12: begin
        pt = b1 * 256 + b0;
        lo = memf(pt); hi = memf((pt / 256) * 256 + (pt + 1) % 256);
        e = hi * 256 + lo; np = (pc + 2) % 65536; rd = 4;
      end
      default: ;
    endcase
    lat = (rd == 0) ? 1 : rd + 2;
  endfunction

  task automatic run_case(input int m, input int pc, input int x, input int y);
    int e_ea, e_pc, e_cr, e_rd, e_lat, lat, rd0;
    bit seen;
    string rq;
    model(m, pc, x, y, e_ea, e_pc, e_cr, e_rd, e_lat);
    rq = req_of(m);
    @(negedge clk);
    start = 1'b1; mode = m[3:0]; pc_in = pc[15:0]; x_idx = x[7:0]; y_idx = y[7:0];
    rd0 = rd_cnt;
    lat = 0; seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(posedge clk); lat++;
      @(negedge clk); start = 1'b0;
      if (ea_valid) seen = 1;
    end
    chk(seen, "R10", "valid seen", int'(seen), 1);
    chk(int'(ea) == e_ea, rq, "address", int'(ea), e_ea);
    chk(int'(pc_next) == e_pc, rq, "next pc", int'(pc_next), e_pc);
    chk(int'(page_cross) == e_cr, rq, "page cross", int'(page_cross), e_cr);
    chk(lat == e_lat, "R10", "latency", lat, e_lat);
    chk((rd_cnt - rd0) == e_rd, "R10", "read count", rd_cnt - rd0, e_rd);
    @(posedge clk);
    @(negedge clk);
    chk(!ea_valid, "R10", "single strobe", int'(ea_valid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(!ea_valid, "R1", "valid after reset", int'(ea_valid), 0);
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!mem_rd, "R1", "read after reset", int'(mem_rd), 0);

    // R4 zero page index wrap
    ovr_n = 0; set_ovr(16'h0400, 8'hF0); run_case(4, 16'h0400, 8'h20, 0);
    ovr_n = 0; set_ovr(16'h0500, 8'hF8); run_case(5, 16'h0500, 0, 8'h10);
    ovr_n = 0; set_ovr(16'h0510, 8'h80); run_case(3, 16'h0510, 0, 0);
    // R5 absolute and indexed carry
    ovr_n = 0; set_ovr(16'h0600, 8'hF0); set_ovr(16'h0601, 8'h12);
    run_case(7, 16'h0600, 8'h20, 0);
    run_case(8, 16'h0600, 0, 8'h05);
    run_case(6, 16'h0600, 0, 0);
    ovr_n = 0; run_case(6, 16'hFFFF, 0, 0);
    // R6 branches both ways
    ovr_n = 0; set_ovr(16'h2000, 8'hF0); run_case(9, 16'h2000, 0, 0);
    ovr_n = 0; set_ovr(16'h3000, 8'h7F); run_case(9, 16'h3000, 0, 0);
    // R7 pointer at 0xFF wraps to 0x00
    ovr_n = 0; set_ovr(16'h0700, 8'hFE); set_ovr(16'h00FF, 8'h34); set_ovr(16'h0000, 8'h12);
    set_ovr(16'h0100, 8'hEE); run_case(10, 16'h0700, 8'h01, 0);
    // R8 post-indexed, pointer at 0xFF, carry into high byte
    ovr_n = 0; set_ovr(16'h0800, 8'hFF); set_ovr(16'h00FF, 8'hF0); set_ovr(16'h0000, 8'h40);
    set_ovr(16'h0100, 8'hEE); run_case(11, 16'h0800, 0, 8'h20);
    // R9 absolute indirect page wrap
    ovr_n = 0; set_ovr(16'h0900, 8'hFF); set_ovr(16'h0901, 8'h30);
    set_ovr(16'h30FF, 8'h78); set_ovr(16'h3000, 8'h56); set_ovr(16'h3100, 8'h99);
    run_case(12, 16'h0900, 0, 0);
    // R2, R3 quick forms
    ovr_n = 0; run_case(2, 16'hFFFF, 0, 0);
    run_case(0, 16'h1234, 0, 0);
    run_case(1, 16'h4321, 0, 0);
    run_case(15, 16'h5555, 0, 0);

    // R11 start held high while busy with a different request
    begin
      int e_ea, e_pc, e_cr, e_rd, e_lat;
      bit seen;
      ovr_n = 0; set_ovr(16'h0A00, 8'h34); set_ovr(16'h0A01, 8'h12);
      model(6, 16'h0A00, 0, 0, e_ea, e_pc, e_cr, e_rd, e_lat);
      @(negedge clk);
      start = 1'b1; mode = 4'd6; pc_in = 16'h0A00;
      @(posedge clk);
      @(negedge clk);
      mode = 4'd2; pc_in = 16'h7777;
      seen = 0;
      for (int k = 0; k < 20 && !seen; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (ea_valid) begin seen = 1; start = 1'b0; end
      end
      chk(int'(ea) == e_ea, "R11", "address kept", int'(ea), e_ea);
      chk(int'(pc_next) == e_pc, "R11", "pc kept", int'(pc_next), e_pc);
      @(posedge clk);
      @(negedge clk);
      chk(!ea_valid, "R11", "no extra strobe", int'(ea_valid), 0);
      start = 1'b0;
    end

    // random mix across all codes
    ovr_n = 0;
    for (int n = 0; n < 300; n++) begin
      run_case(int'($urandom % 16), int'($urandom % 65536),
               int'($urandom % 256), int'($urandom % 256));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule